// File: doc/BRIEF.md
# Mouse Command Error and Resend Handler

This block sits between the byte link of a pointing device and its command logic. Each byte from the host arrives with a parity-error flag and a flag that says whether the byte is an accepted command. The block decides how to answer a bad byte. A first bad byte in a run draws a request for the host to send again. A second bad byte in a row draws an error code, and the run then starts over. Any good command other than the Resend code makes the block pulse a clear to the motion accumulator.

The block also keeps the last unit that the device sent in full. A unit is one byte or a movement packet of up to three bytes. When the host sends the Resend code, the block sends that unit again, byte for byte, and does not clear the motion counters. Units from the command logic pass through a one-unit sequencer to the link. The link acknowledges each byte or reports contention, and after contention the byte is offered again. Answers owed to the host take precedence over a unit that is still waiting to start.

Top module: `mrh_top`

## Requirements
- R1: After reset, tx_valid and clr_motion are low and app_ready is high.
- R2: A host byte that is invalid (rx_par_err high, or rx_cmd_ok low on a byte other than 0xFE) and opens a run of bad bytes is answered with the single byte 0xFE.
- R3: A second invalid byte directly after an invalid one is answered with the single byte 0xFC, and the run starts over, so the next invalid byte is answered with 0xFE again.
- R4: Any valid host byte ends the run of bad bytes, so the invalid byte after it is answered with 0xFE.
- R5: A valid host byte other than 0xFE, with rx_par_err low and rx_cmd_ok high, raises clr_motion for exactly the one cycle after the byte is received, and no byte is sent in answer.
- R6: The byte 0xFE received with rx_par_err low, whatever rx_cmd_ok is, makes the block send again every byte of the last stored unit in the original order, and clr_motion stays low.
- R7: The stored unit is replaced only when a unit from app_data has had its last byte acknowledged; the answers 0xFE and 0xFC and a replay leave it unchanged.
- R8: When tx_abort is raised for a byte, that byte stays offered on tx_byte and its position in the unit does not advance.
- R9: While tx_valid is high and tx_ack has not been raised, tx_byte holds its value. A unit is sent starting with app_data[7:0], then app_data[15:8], then app_data[23:16], for app_len bytes.
- R10: A host byte that needs an answer and arrives in the same cycle as a waiting unit is answered before that unit starts, and app_ready is low during that cycle.
- R11: Whenever an answer is owed, the block starts offering it on tx_valid within RESP_MAX cycles of receiving the host byte, as long as no unit is in progress.
- R12: A Resend received while no unit has ever been stored sends nothing and raises no clr_motion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A host byte is present this cycle |
| rx_byte | input | 8 | Host byte |
| rx_par_err | input | 1 | The host byte failed its parity check |
| rx_cmd_ok | input | 1 | The command logic accepts the host byte as a command |
| app_valid | input | 1 | The command logic offers a unit to send |
| app_len | input | 2 | Number of bytes in the offered unit, 1 to 3 |
| app_data | input | 24 | Unit bytes, with the first byte in bits 7:0 |
| app_ready | output | 1 | The offered unit is accepted this cycle |
| tx_valid | output | 1 | A byte is offered to the link |
| tx_byte | output | 8 | Byte offered to the link |
| tx_ack | input | 1 | The link sent the offered byte without contention |
| tx_abort | input | 1 | The link hit contention on the offered byte |
| clr_motion | output | 1 | One-cycle clear to the motion accumulator |

## Verification
The assertions check on every cycle the rules that can be seen in a single cycle or across adjacent cycles. These are: a clear has a valid non-Resend byte as its cause; a valid Resend is never followed by a clear; the offered byte holds until it is acknowledged; the stored unit stays unchanged unless a write occurs; and an owed answer is never left waiting for longer than the limit. Some behaviour depends on the history of several bytes, and only the bench scenarios show it. This covers the step from 0xFE to 0xFC and back again, the end of a run on a valid byte, the retry of a byte after contention, replay of a three-byte unit after an error answer, and answers taking precedence over a waiting unit.

// File: rtl/mrh_pkg.sv
package mrh_pkg;

    // Action owed to the host after a received byte
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_ASK    = 2'd1,
        ACT_FAULT  = 2'd2,
        ACT_REPLAY = 2'd3
    } act_e;

endpackage

// File: rtl/mrh_err_track.sv
module mrh_err_track
    import mrh_pkg::*;
#(
    parameter int          DW         = 8,
    parameter int          RUN_LIMIT  = 2,
    parameter logic [DW-1:0] CODE_ASK = 8'hFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          rx_par_err_i,
    input  logic          rx_cmd_ok_i,
    input  logic          take_i,
    output logic          pend_o,
    output act_e          act_o,
    output logic          clr_o
);

    localparam int RW = $clog2(RUN_LIMIT + 1);

    typedef struct packed {
        logic [RW-1:0] run;
        logic          pend;
        act_e          act;
        logic          clr;
    } trk_t;

    trk_t s_d, s_q;
    logic is_resend, is_bad;

    always_comb begin
        is_resend = (rx_byte_i == CODE_ASK) && !rx_par_err_i;
        is_bad    = rx_par_err_i || (!rx_cmd_ok_i && !is_resend);
        s_d       = s_q;
        s_d.clr   = 1'b0;
        if (take_i) begin
            s_d.pend = 1'b0;
        end
        if (rx_valid_i) begin
            if (is_bad) begin
                s_d.pend = 1'b1;
                if (s_q.run == RW'(RUN_LIMIT - 1)) begin
                    s_d.act = ACT_FAULT;
                    s_d.run = '0;
                end else begin
                    s_d.act = ACT_ASK;
                    s_d.run = s_q.run + RW'(1);
                end
            end else begin
                s_d.run = '0;
                if (is_resend) begin
                    s_d.pend = 1'b1;
                    s_d.act  = ACT_REPLAY;
                end else begin
                    s_d.clr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{run: '0, pend: 1'b0, act: ACT_NONE, clr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign act_o  = s_q.act;
    assign clr_o  = s_q.clr;

    // R5
    clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> $past(rx_valid_i && !rx_par_err_i && rx_cmd_ok_i && (rx_byte_i != CODE_ASK)));

    // R6
    resend_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !rx_par_err_i && (rx_byte_i == CODE_ASK)) |=> !clr_o);

    // R2
    bad_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && rx_par_err_i) |=> (pend_o && (act_o != ACT_REPLAY)));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run < RW'(RUN_LIMIT));

endmodule

// File: rtl/mrh_last_unit.sv
module mrh_last_unit #(
    parameter int DW      = 8,
    parameter int MAX_LEN = 3,
    parameter int LW      = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [LW-1:0]                 wlen_i,
    input  logic [MAX_LEN-1:0][DW-1:0]    wdata_i,
    output logic [LW-1:0]                 len_o,
    output logic [MAX_LEN-1:0][DW-1:0]    data_o
);

    typedef struct packed {
        logic [LW-1:0]              len;
        logic [MAX_LEN-1:0][DW-1:0] data;
    } unit_t;

    unit_t u_d, u_q;

    always_comb begin
        u_d = u_q;
        if (we_i) begin
            u_d.len  = wlen_i;
            u_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q <= '0;
        end else begin
            u_q <= u_d;
        end
    end

    assign len_o  = u_q.len;
    assign data_o = u_q.data;

    // R7
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(len_o) && $stable(data_o)));

endmodule

// File: rtl/mrh_tx_seq.sv
module mrh_tx_seq
    import mrh_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            MAX_LEN    = 3,
    parameter int            LW         = 2,
    parameter logic [DW-1:0] CODE_ASK   = 8'hFE,
    parameter logic [DW-1:0] CODE_FAULT = 8'hFC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pend_i,
    input  act_e                       act_i,
    output logic                       take_o,
    input  logic                       rx_valid_i,
    input  logic                       app_valid_i,
    input  logic [LW-1:0]              app_len_i,
    input  logic [MAX_LEN-1:0][DW-1:0] app_data_i,
    output logic                       app_ready_o,
    input  logic [LW-1:0]              st_len_i,
    input  logic [MAX_LEN-1:0][DW-1:0] st_data_i,
    output logic                       st_we_o,
    output logic [LW-1:0]              st_wlen_o,
    output logic [MAX_LEN-1:0][DW-1:0] st_wdata_o,
    output logic                       tx_valid_o,
    output logic [DW-1:0]              tx_byte_o,
    input  logic                       tx_ack_i,
    input  logic                       tx_abort_i,
    output logic                       busy_o
);

    typedef struct packed {
        logic                       busy;
        logic                       keep;
        logic [LW-1:0]              idx;
        logic [LW-1:0]              len;
        logic [MAX_LEN-1:0][DW-1:0] bytes;
    } seq_t;

    seq_t s_d, s_q;
    logic sent_ok;

    always_comb begin
        s_d         = s_q;
        take_o      = !s_q.busy && pend_i;
        app_ready_o = !s_q.busy && !pend_i && !rx_valid_i;
        sent_ok     = tx_ack_i && !tx_abort_i;
        st_we_o     = 1'b0;
        if (s_q.busy) begin
            if (sent_ok) begin
                if (s_q.idx == s_q.len - LW'(1)) begin
                    s_d.busy = 1'b0;
                    st_we_o  = s_q.keep;
                end else begin
                    s_d.idx = s_q.idx + LW'(1);
                end
            end
        end else if (take_o) begin
            s_d.idx  = '0;
            s_d.keep = 1'b0;
            case (act_i)
                ACT_REPLAY: begin
                    s_d.bytes = st_data_i;
                    s_d.len   = st_len_i;
                    s_d.busy  = (st_len_i != '0);
                end
                ACT_FAULT: begin
                    s_d.bytes    = '0;
                    s_d.bytes[0] = CODE_FAULT;
                    s_d.len      = LW'(1);
                    s_d.busy     = 1'b1;
                end
                default: begin
                    s_d.bytes    = '0;
                    s_d.bytes[0] = CODE_ASK;
                    s_d.len      = LW'(1);
                    s_d.busy     = 1'b1;
                end
            endcase
        end else if (app_valid_i && app_ready_o) begin
            s_d.idx   = '0;
            s_d.keep  = 1'b1;
            s_d.bytes = app_data_i;
            s_d.len   = app_len_i;
            s_d.busy  = (app_len_i != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_valid_o = s_q.busy;
    assign tx_byte_o  = s_q.bytes[s_q.idx];
    assign st_wlen_o  = s_q.len;
    assign st_wdata_o = s_q.bytes;
    assign busy_o     = s_q.busy;

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ack_i) |=> (tx_valid_o && $stable(tx_byte_o)));

    // R9
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (app_valid_i && app_ready_o && (app_len_i != '0)) |=>
            (tx_valid_o && (tx_byte_o == $past(app_data_i[0]))));

    // R10
    answer_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && app_valid_i) |-> !app_ready_o);

    // R8
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_abort_i) |=> (tx_valid_o && $stable(tx_byte_o)));

endmodule

// File: rtl/mrh_top.sv
module mrh_top
    import mrh_pkg::*;
#(
    parameter int            DW         = 8,
    parameter int            MAX_LEN    = 3,
    parameter int            RUN_LIMIT  = 2,
    parameter int            RESP_MAX   = 4,
    parameter logic [DW-1:0] CODE_ASK   = 8'hFE,
    parameter logic [DW-1:0] CODE_FAULT = 8'hFC,
    localparam int           LW         = $clog2(MAX_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [DW-1:0]         rx_byte,
    input  logic                  rx_par_err,
    input  logic                  rx_cmd_ok,
    input  logic                  app_valid,
    input  logic [LW-1:0]         app_len,
    input  logic [MAX_LEN*DW-1:0] app_data,
    output logic                  app_ready,
    output logic                  tx_valid,
    output logic [DW-1:0]         tx_byte,
    input  logic                  tx_ack,
    input  logic                  tx_abort,
    output logic                  clr_motion
);

    localparam int CW = $clog2(RESP_MAX + 2);

    logic                       pend, take, st_we, busy;
    act_e                       act;
    logic [LW-1:0]              st_len, st_wlen;
    logic [MAX_LEN-1:0][DW-1:0] st_data, st_wdata, app_bytes;

    assign app_bytes = app_data;

    mrh_err_track #(
        .DW(DW), .RUN_LIMIT(RUN_LIMIT), .CODE_ASK(CODE_ASK)
    ) u_trk (
        .clk(clk), .rst_n(rst_n),
        .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .rx_par_err_i(rx_par_err), .rx_cmd_ok_i(rx_cmd_ok),
        .take_i(take), .pend_o(pend), .act_o(act), .clr_o(clr_motion)
    );

    mrh_last_unit #(
        .DW(DW), .MAX_LEN(MAX_LEN), .LW(LW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(st_we), .wlen_i(st_wlen), .wdata_i(st_wdata),
        .len_o(st_len), .data_o(st_data)
    );

    mrh_tx_seq #(
        .DW(DW), .MAX_LEN(MAX_LEN), .LW(LW),
        .CODE_ASK(CODE_ASK), .CODE_FAULT(CODE_FAULT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend), .act_i(act), .take_o(take),
        .rx_valid_i(rx_valid),
        .app_valid_i(app_valid), .app_len_i(app_len),
        .app_data_i(app_bytes), .app_ready_o(app_ready),
        .st_len_i(st_len), .st_data_i(st_data),
        .st_we_o(st_we), .st_wlen_o(st_wlen), .st_wdata_o(st_wdata),
        .tx_valid_o(tx_valid), .tx_byte_o(tx_byte),
        .tx_ack_i(tx_ack), .tx_abort_i(tx_abort), .busy_o(busy)
    );

    // Cycles an owed answer has waited with nothing on the link
    logic [CW-1:0] owe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owe_q <= '0;
        end else if (pend && !tx_valid && !busy) begin
            if (owe_q != {CW{1'b1}}) begin
                owe_q <= owe_q + CW'(1);
            end
        end else begin
            owe_q <= '0;
        end
    end

    // R11
    answer_deadline_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owe_q <= CW'(RESP_MAX));

endmodule

// File: tb/tb_mrh_top.sv
module tb_mrh_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_cmd_ok = 1'b0;
    logic        app_valid = 1'b0;
    logic [1:0]  app_len = '0;
    logic [23:0] app_data = '0;
    logic        app_ready;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ack = 1'b0;
    logic        tx_abort = 1'b0;
    logic        clr_motion;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mrh_top dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_par_err(rx_par_err), .rx_cmd_ok(rx_cmd_ok),
        .app_valid(app_valid), .app_len(app_len), .app_data(app_data),
        .app_ready(app_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ack(tx_ack), .tx_abort(tx_abort),
        .clr_motion(clr_motion)
    );

    // {byte[18:11], par_err[10], cmd_ok[9], expected tx[8:1] (0 = none), expected clear[0]}
    localparam int NV = 9;
    localparam logic [18:0] VEC [NV] = '{
        {8'h55, 1'b0, 1'b1, 8'h00, 1'b1},
        {8'h10, 1'b0, 1'b0, 8'hFE, 1'b0},
        {8'h11, 1'b0, 1'b0, 8'hFC, 1'b0},
        {8'h12, 1'b0, 1'b0, 8'hFE, 1'b0},
        {8'hF4, 1'b0, 1'b1, 8'h00, 1'b1},
        {8'h13, 1'b1, 1'b1, 8'hFE, 1'b0},
        {8'hE8, 1'b0, 1'b1, 8'h00, 1'b1},
        {8'h20, 1'b0, 1'b0, 8'hFE, 1'b0},
        {8'hFE, 1'b1, 1'b1, 8'hFC, 1'b0}
    };

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Present one host byte; returns at the negedge after the capturing edge
    task automatic put_rx(input logic [7:0] b, input logic pe, input logic ok);
        rx_byte = b; rx_par_err = pe; rx_cmd_ok = ok; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Wait for an offered byte, check it, acknowledge it
    task automatic take_tx(input logic [7:0] exp, input string tag, output int lat);
        lat = 0;
        while (!tx_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(tx_valid && tx_byte == exp, tag, tx_valid ? int'(tx_byte) : -1, int'(exp));
        tx_ack = 1'b1;
        @(negedge clk);
        tx_ack = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        logic seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (tx_valid || clr_motion) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, tag, int'(seen), 0);
    endtask

    task automatic send_app(input logic [1:0] len, input logic [23:0] d);
        app_len = len; app_data = d; app_valid = 1'b1;
        while (!app_ready) @(negedge clk);
        @(negedge clk);
        app_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!tx_valid && !clr_motion && app_ready, "R1 reset outputs",
            {tx_valid, clr_motion, app_ready}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_valid && !clr_motion && app_ready, "R1 after reset",
            {tx_valid, clr_motion, app_ready}, 3'b001);

        // R12 resend with empty store
        put_rx(8'hFE, 1'b0, 1'b0);
        quiet(8, "R12 empty resend silent");

        // Table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            put_rx(VEC[i][18:11], VEC[i][10], VEC[i][9]);
            chk(clr_motion == VEC[i][0], $sformatf("R5 clear vec %0d", i),
                int'(clr_motion), int'(VEC[i][0]));
            if (VEC[i][8:1] != 8'h00) begin
                take_tx(VEC[i][8:1], $sformatf("R2 R3 R4 answer vec %0d", i), lat);
                chk(lat <= 3, $sformatf("R11 latency vec %0d", i), lat, 3);
            end else begin
                @(negedge clk);
                chk(!clr_motion, $sformatf("R5 one-cycle clear vec %0d", i), int'(clr_motion), 0);
                quiet(3, $sformatf("R5 no answer vec %0d", i));
            end
        end

        // R9 R8: three-byte unit with contention on the second byte
        send_app(2'd3, 24'hC3B2A1);
        take_tx(8'hA1, "R9 unit byte 0", lat);
        while (!tx_valid) @(negedge clk);
        tx_abort = 1'b1;
        @(negedge clk);
        tx_abort = 1'b0;
        chk(tx_valid && tx_byte == 8'hB2, "R8 byte kept after abort", int'(tx_byte), 8'hB2);
        take_tx(8'hB2, "R8 R9 unit byte 1", lat);
        take_tx(8'hC3, "R9 unit byte 2", lat);
        quiet(3, "R9 unit ends");

        // R6 replay without clear
        put_rx(8'hFE, 1'b0, 1'b1);
        chk(!clr_motion, "R6 no clear on resend", int'(clr_motion), 0);
        take_tx(8'hA1, "R6 replay byte 0", lat);
        take_tx(8'hB2, "R6 replay byte 1", lat);
        take_tx(8'hC3, "R6 replay byte 2", lat);
        quiet(3, "R6 replay ends");

        // R7 error answer does not overwrite store
        put_rx(8'h33, 1'b0, 1'b0);
        take_tx(8'hFE, "R7 ask answer", lat);
        put_rx(8'hFE, 1'b0, 1'b1);
        take_tx(8'hA1, "R7 store kept byte 0", lat);
        take_tx(8'hB2, "R7 store kept byte 1", lat);
        take_tx(8'hC3, "R7 store kept byte 2", lat);

        // R7 one-byte unit replaces store
        send_app(2'd1, 24'h0000FA);
        take_tx(8'hFA, "R7 single unit", lat);
        put_rx(8'hFE, 1'b0, 1'b1);
        take_tx(8'hFA, "R7 replay single", lat);
        quiet(3, "R7 single replay length");

        // R10 answer takes precedence over a waiting unit
        rx_byte = 8'h44; rx_par_err = 1'b0; rx_cmd_ok = 1'b0; rx_valid = 1'b1;
        app_len = 2'd2; app_data = 24'h007766; app_valid = 1'b1;
        #1;
        chk(!app_ready, "R10 app_ready low with host byte", int'(app_ready), 0);
        @(negedge clk);
        rx_valid = 1'b0;
        fork
            begin
                while (!app_ready) @(negedge clk);
                @(negedge clk);
                app_valid = 1'b0;
            end
            begin
                int l2;
                take_tx(8'hFE, "R10 answer first", l2);
                take_tx(8'h66, "R10 unit byte 0", l2);
                take_tx(8'h77, "R10 unit byte 1", l2);
            end
        join
        quiet(3, "R10 nothing extra");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule